// File: doc/BRIEF.md
# Timer Channel with Capture and GPIO Modes

This block is one channel of a timer. A 7-bit mode field picks its job. In general-purpose input mode it watches a pin for a chosen edge. In general-purpose output mode it drives a pin from a control bit. In single-action capture mode it stamps the value of an external time-base bus into a data register on each qualifying pin edge. In both capture and input mode, a qualifying edge raises an event flag. Software clears this flag by writing a one to it.

The pin passes through a two-flop synchronizer. An edge detector follows, steered by two control bits. Each data register, A and B, is a pair: a primary copy and a secondary copy. In either general-purpose mode, a write loads both copies, so the channel can be set up for its next mode before it is switched. In capture mode, a write reaches only the primary copy. Reads of A then return the secondary copy, which holds the last captured stamp.

Top module: `tmr_chan`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and `pin_out` is 0. The mode is then 0, which is general-purpose input.
- R2: The register at address 0 is the control register. Bits [6:0] hold the mode, bit 8 is the polarity bit and bit 9 is the both-edge bit. Every one of these bits reads back as written, whatever the mode. Mode 0 is input, mode 1 is output and mode 2 is capture. All other mode codes are inactive.
- R3: In mode 0 or mode 1, a write to address 1 (data A) loads both the A primary and the A secondary copy. A write to address 2 (data B) loads both B copies. Reads of A and B return the primary copies.
- R4: In mode 2, a write to A changes only the A primary copy, and a read of A returns the A secondary copy. In every other mode, a read of A returns the A primary copy. B writes and reads use the B primary copy in every mode.
- R5: Edge selection works as follows. With the both-edge bit at 1, rising and falling edges both qualify and polarity is ignored. With the both-edge bit at 0, polarity 1 selects rising edges and polarity 0 selects falling edges.
- R6: In mode 0, a qualifying pin edge sets the flag. The flag is status bit 0, at address 3. A pin change made before clock edge e0 sets the flag at edge e2.
- R7: Status bit 1 reads the synchronized pin level. It follows the pin two clock edges later.
- R8: In mode 2, a qualifying edge copies `tbase` into the A secondary copy and sets the flag, both at the same clock edge.
- R9: In mode 1, `pin_out` takes the value of the polarity bit one cycle after that bit changes. Pin edges in mode 1 never set the flag.
- R10: Writing status with bit 0 at 1 clears the flag, and writing 0 has no effect. When an event and a clearing write fall in the same cycle, the event wins.
- R11: In any mode code other than 0, 1 and 2, pin edges neither set the flag nor capture. In these modes `pin_out` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 A, 2 B, 3 status) |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` (combinational) |
| tbase | input | DW | External time-base value |
| pin_in | input | 1 | Asynchronous input pin |
| pin_out | output | 1 | Output pin flip-flop |

## Verification
The bound checker watches several rules on every cycle:
- A qualifying edge in input mode sets the flag.
- In capture mode, the stamp equals the time base of the event cycle.
- In output mode, `pin_out` tracks the polarity bit.
- A clear with no event behind it drops the flag.
- Both copies stay equal after a general-purpose write.
- Inactive codes never raise the flag or alter the stamp.

Other behaviour shows only in the bench's scenarios:
- the read source switching between copies as the mode changes;
- the edge choice for each polarity and both-edge setting;
- the synchronizer latency seen at the status register;
- the event beating a coincident clear.

// File: rtl/tmr_chan_pkg.sv
// Package: shared encodings for the timer channel.
// Assumes the data width is at least 10 bits so the control fields fit.
package tmr_chan_pkg;
    localparam int MODE_W = 7;

    localparam logic [MODE_W-1:0] MD_GPIO_IN  = 7'h00;
    localparam logic [MODE_W-1:0] MD_GPIO_OUT = 7'h01;
    localparam logic [MODE_W-1:0] MD_CAPTURE  = 7'h02;

    localparam int CTRL_POL_BIT = 8;
    localparam int CTRL_SEL_BIT = 9;
    localparam int STAT_FLG_BIT = 0;
    localparam int STAT_LVL_BIT = 1;

    typedef enum logic [1:0] {
        AD_CTRL = 2'd0,
        AD_DATA_A = 2'd1,
        AD_DATA_B = 2'd2,
        AD_STAT = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/tmr_chan_sync.sv
// Pin synchronizer and edge qualifier.
// Does: brings pin_in through STAGES flops, keeps one more flop of history,
//       and flags a qualifying edge according to polarity / both-edge bits.
// Assumes: pin_in is asynchronous; qual is combinational from flops.
module tmr_chan_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic edpol,
    input  logic edsel,
    output logic level,
    output logic qual
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;
    logic               prev;
    logic               rise;
    logic               fall;

    // Shift the pin through the synchronizer and the history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN_W-2:0], pin_in};
    end

    assign level = chain_q[STAGES-1];
    assign prev  = chain_q[STAGES];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;

    // Pick which edge counts.
    always_comb begin
        if (edsel)      qual = rise | fall;
        else if (edpol) qual = rise;
        else            qual = fall;
    end
endmodule

// File: rtl/tmr_chan_data.sv
// Data register pairs A and B (primary and secondary copy each).
// Does: a write loads the primary copy, and the secondary copy too in
//       general-purpose modes. Pair A secondary takes the time base on a capture.
// Assumes: cap_evt is asserted only in capture mode.
module tmr_chan_data #(
    parameter int DW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          wr_sel,
    input  logic [DW-1:0]       wdata,
    input  logic                gpio_md,
    input  logic                cap_evt,
    input  logic [DW-1:0]       tbase,
    output logic [1:0][DW-1:0]  prim,
    output logic [1:0][DW-1:0]  sec
);
    localparam int NPAIR = 2;

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        localparam bit IS_A = (k == 0);
        logic [DW-1:0] p_q;
        logic [DW-1:0] s_q;

        // Update one pair from writes and, for pair A, from captures.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                p_q <= '0;
                s_q <= '0;
            end else begin
                if (wr_sel[k]) begin
                    p_q <= wdata;
                    if (gpio_md) s_q <= wdata;
                end
                if (IS_A && cap_evt) s_q <= tbase;
            end
        end

        assign prim[k] = p_q;
        assign sec[k]  = s_q;
    end
endmodule

// File: rtl/tmr_chan.sv
// Top: one timer channel in general-purpose in/out or single-action capture.
// Does: holds control, flag and output flip-flop, steers events to the
//       data pairs and muxes register reads.
// Assumes: reg_rdata is sampled combinationally by the host; DW >= 10.
module tmr_chan
    import tmr_chan_pkg::*;
#(
    parameter int DW = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [DW-1:0] tbase,
    input  logic          pin_in,
    output logic          pin_out
);
    localparam int CTRL_PAD = DW - (CTRL_SEL_BIT + 1);
    localparam int STAT_PAD = DW - 2;

    logic [MODE_W-1:0] mode_q;
    logic              edpol_q;
    logic              edsel_q;
    logic              flag_q;
    logic              pin_out_q;
    logic              level;
    logic              qual;
    logic              gpio_md;
    logic              evt;
    logic              cap_evt;
    logic              wr_ctrl;
    logic              wr_stat;
    logic [1:0]        wr_sel;
    logic [1:0][DW-1:0] prim;
    logic [1:0][DW-1:0] sec;
    logic [DW-1:0]     a_rd;

    assign gpio_md = (mode_q[MODE_W-1:1] == '0);
    assign evt     = qual & ((mode_q == MD_GPIO_IN) | (mode_q == MD_CAPTURE));
    assign cap_evt = qual & (mode_q == MD_CAPTURE);
    assign wr_ctrl = reg_wr & (reg_addr == AD_CTRL);
    assign wr_stat = reg_wr & (reg_addr == AD_STAT);
    assign wr_sel  = {reg_wr & (reg_addr == AD_DATA_B),
                      reg_wr & (reg_addr == AD_DATA_A)};

    tmr_chan_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .edpol(edpol_q), .edsel(edsel_q),
        .level(level), .qual(qual)
    );

    tmr_chan_data #(.DW(DW)) u_data (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wdata(reg_wdata),
        .gpio_md(gpio_md), .cap_evt(cap_evt), .tbase(tbase),
        .prim(prim), .sec(sec)
    );

    // Control register: mode and edge bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MD_GPIO_IN;
            edpol_q <= 1'b0;
            edsel_q <= 1'b0;
        end else if (wr_ctrl) begin
            mode_q  <= reg_wdata[MODE_W-1:0];
            edpol_q <= reg_wdata[CTRL_POL_BIT];
            edsel_q <= reg_wdata[CTRL_SEL_BIT];
        end
    end

    // Event flag: set by an event, cleared by write-one, event has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                               flag_q <= 1'b0;
        else if (evt)                             flag_q <= 1'b1;
        else if (wr_stat && reg_wdata[STAT_FLG_BIT]) flag_q <= 1'b0;
    end

    // Output flip-flop: copies polarity while in output mode, else holds.
    always_ff @(posedge clk) begin
        if (!rst_n)                        pin_out_q <= 1'b0;
        else if (mode_q == MD_GPIO_OUT)    pin_out_q <= edpol_q;
    end

    assign pin_out = pin_out_q;
    assign a_rd    = (mode_q == MD_CAPTURE) ? sec[0] : prim[0];

    // Read mux.
    always_comb begin
        unique case (reg_addr)
            AD_CTRL:   reg_rdata = {{CTRL_PAD{1'b0}}, edsel_q, edpol_q, 1'b0, mode_q};
            AD_DATA_A: reg_rdata = a_rd;
            AD_DATA_B: reg_rdata = prim[1];
            default:   reg_rdata = {{STAT_PAD{1'b0}}, level, flag_q};
        endcase
    end
endmodule

// File: rtl/tmr_chan_chk.sv
// Checker for tmr_chan, bound to every instance.
// Assumes: signals are sampled at the rising clock edge.
module tmr_chan_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [6:0]    mode,
    input logic          edpol,
    input logic          qual,
    input logic          flag,
    input logic          pin_out,
    input logic          reg_wr,
    input logic [1:0]    reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] tbase,
    input logic [DW-1:0] a1,
    input logic [DW-1:0] a2,
    input logic [DW-1:0] b1,
    input logic [DW-1:0] b2
);
    assert_gpio_in_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 7'h00 && qual) |=> flag);

    assert_capture_stamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 7'h02 && qual) |=> (flag && a2 == $past(tbase)));

    assert_out_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 7'h01) |=> (pin_out == $past(edpol)));

    assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd3 && reg_wdata[0] &&
         !(qual && (mode == 7'h00 || mode == 7'h02))) |=> !flag);

    assert_shadow_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[6:1] == 6'd0 && reg_wr && reg_addr == 2'd1)
        |=> (a1 == $past(reg_wdata) && a2 == $past(reg_wdata)));

    assert_shadow_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[6:1] == 6'd0 && reg_wr && reg_addr == 2'd2)
        |=> (b1 == $past(reg_wdata) && b2 == $past(reg_wdata)));

    assert_idle_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode > 7'h02) |=> (!$rose(flag) && $stable(a2) && $stable(pin_out)));
endmodule

bind tmr_chan tmr_chan_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .edpol(edpol_q), .qual(qual),
    .flag(flag_q), .pin_out(pin_out), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tbase(tbase),
    .a1(prim[0]), .a2(sec[0]), .b1(prim[1]), .b2(sec[1])
);

// File: tb/tb_tmr_chan.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected values, a monitor compares.
module tb_tmr_chan;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [DW-1:0] tbase = '0;
    logic          pin_in = 1'b0;
    logic          pin_out;

    int total = 0;
    int bad = 0;
    int req_cnt = 0;
    int served = 0;
    bit done = 1'b0;

    typedef struct {
        bit            is_pin;
        logic [DW-1:0] exp;
        string         req;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    tmr_chan #(.DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tbase(tbase),
        .pin_in(pin_in), .pin_out(pin_out)
    );

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic chk_reg(input logic [1:0] a, input logic [DW-1:0] e, input string r);
        item_t it;
        @(negedge clk);
        reg_addr = a;
        it.is_pin = 1'b0; it.exp = e; it.req = r;
        sb_q.push_back(it);
        req_cnt++;
    endtask

    task automatic chk_pin(input logic e, input string r);
        item_t it;
        @(negedge clk);
        it.is_pin = 1'b1; it.exp = {{(DW-1){1'b0}}, e}; it.req = r;
        sb_q.push_back(it);
        req_cnt++;
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk);
        pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    // Monitor: pop queued expectations and compare after the inputs settle.
    always @(negedge clk) begin
        #1;
        while (served < req_cnt) begin
            item_t it;
            logic [DW-1:0] act;
            it = sb_q.pop_front();
            served++;
            act = it.is_pin ? {{(DW-1){1'b0}}, pin_out} : reg_rdata;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk_reg(2'd0, 16'h0000, "R1 ctrl");
        chk_reg(2'd1, 16'h0000, "R1 A");
        chk_reg(2'd2, 16'h0000, "R1 B");
        chk_reg(2'd3, 16'h0000, "R1 status");
        chk_pin(1'b0, "R1 pin_out");
        // R2: control fields read back
        wr(2'd0, 16'h037F);
        chk_reg(2'd0, 16'h037F, "R2 all fields");
        wr(2'd0, 16'h0000);
        chk_reg(2'd0, 16'h0000, "R2 cleared");
        // R3: writes in general-purpose mode fill both copies
        wr(2'd1, 16'h1234);
        wr(2'd2, 16'hBEEF);
        chk_reg(2'd1, 16'h1234, "R3 A read");
        chk_reg(2'd2, 16'hBEEF, "R3 B read");
        wr(2'd0, 16'h0002);
        chk_reg(2'd1, 16'h1234, "R3 A secondary loaded");
        // R4: capture mode writes only the primary copy
        wr(2'd1, 16'h5555);
        chk_reg(2'd1, 16'h1234, "R4 A read is secondary");
        wr(2'd2, 16'h7777);
        chk_reg(2'd2, 16'h7777, "R4 B read");
        // R5/R6/R7: input mode, rising edge
        wr(2'd0, 16'h0100);
        chk_reg(2'd1, 16'h5555, "R4 A read is primary outside capture");
        set_pin(1'b1);
        chk_reg(2'd3, 16'h0003, "R6 rising flag R7 level");
        wr(2'd3, 16'h0001);
        chk_reg(2'd3, 16'h0002, "R10 clear");
        wr(2'd3, 16'h0000);
        chk_reg(2'd3, 16'h0002, "R10 write zero no effect");
        set_pin(1'b0);
        chk_reg(2'd3, 16'h0000, "R5 falling ignored when rising chosen");
        // R5: falling edge selection
        wr(2'd0, 16'h0000);
        set_pin(1'b1);
        chk_reg(2'd3, 16'h0002, "R5 rising ignored when falling chosen");
        set_pin(1'b0);
        chk_reg(2'd3, 16'h0001, "R5 falling flag");
        wr(2'd3, 16'h0001);
        // R5: both edges
        wr(2'd0, 16'h0200);
        set_pin(1'b1);
        chk_reg(2'd3, 16'h0003, "R5 both rise");
        wr(2'd3, 16'h0001);
        set_pin(1'b0);
        chk_reg(2'd3, 16'h0001, "R5 both fall");
        // R10: event coincident with clear wins (flag already set)
        @(negedge clk) pin_in = 1'b1;
        @(negedge clk);
        wr(2'd3, 16'h0001);
        repeat (3) @(negedge clk);
        chk_reg(2'd3, 16'h0003, "R10 event beats clear");
        wr(2'd3, 16'h0001);
        set_pin(1'b0);
        wr(2'd3, 16'h0001);
        chk_reg(2'd3, 16'h0000, "R10 cleared");
        // R8: capture
        tbase = 16'h00A5;
        wr(2'd0, 16'h0102);
        set_pin(1'b1);
        chk_reg(2'd1, 16'h00A5, "R8 stamp rising");
        chk_reg(2'd3, 16'h0003, "R8 flag");
        wr(2'd3, 16'h0001);
        tbase = 16'h0C3C;
        set_pin(1'b0);
        chk_reg(2'd1, 16'h00A5, "R8 R5 falling no capture");
        chk_reg(2'd3, 16'h0000, "R8 no flag");
        wr(2'd0, 16'h0202);
        tbase = 16'h0F0F;
        set_pin(1'b1);
        chk_reg(2'd1, 16'h0F0F, "R8 both-edge capture");
        wr(2'd3, 16'h0001);
        // R9: output mode
        wr(2'd0, 16'h0101);
        repeat (2) @(negedge clk);
        chk_pin(1'b1, "R9 pin_out follows polarity 1");
        set_pin(1'b0);
        chk_reg(2'd3, 16'h0000, "R9 no flag in output mode");
        wr(2'd0, 16'h0001);
        repeat (2) @(negedge clk);
        chk_pin(1'b0, "R9 pin_out follows polarity 0");
        // R11: inactive mode code
        wr(2'd0, 16'h0101);
        repeat (2) @(negedge clk);
        wr(2'd0, 16'h0205);
        repeat (2) @(negedge clk);
        chk_pin(1'b1, "R11 pin_out holds");
        tbase = 16'h3333;
        set_pin(1'b1);
        chk_reg(2'd3, 16'h0002, "R11 no flag");
        wr(2'd0, 16'h0102);
        chk_reg(2'd1, 16'h0F0F, "R11 no capture");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule